// File: doc/BRIEF.md
# Fixed-Delay Implication Monitor

This block is a synthesizable run-time checker for one temporal rule: whenever the trigger input is high, the value input must be high exactly `DELAY` clock cycles later. It can sit next to any datapath in silicon or in an emulation build. Each clock cycle it reports the outcome of any attempt whose window closes in that cycle. It gives a one-cycle `pass` pulse when value is high and a one-cycle `fail` pulse when value is low.

Each attempt in flight is held as a single set bit in a chain of stage flops, and the chain advances one position per clock. A trigger in every cycle is legal, so many attempts can be in flight at once, each in its own stage. The chain is built from several slices, and no slice is wider than `CHUNK_W` bits. The top stage of each slice feeds bit 0 of the next slice. The abort input `dis` behaves like a disable condition. While it is high, every stage bit is forced to zero and no verdict is produced. Any attempt whose window includes a cycle with `dis` high is therefore dropped.

Top module: `delay_assert_mon`

## Requirements
- R1: `rst_n` is an active-low synchronous reset. A cycle with `rst_n` low drops every pending attempt, including one triggered in that same cycle. `fail` and `pass` are low during that cycle.
- R2: A trigger in cycle t, with `dis` low and `rst_n` high from t through t+DELAY, produces exactly one verdict, in cycle t+DELAY. That verdict is `fail`=1 if value is low and `pass`=1 if value is high. This timing holds for the default DELAY=130, which spans three slices of 64, 64 and 2 bits.
- R3: The value input is ignored in every cycle except the one where an attempt's window closes. Value low at t+DELAY-1 or t+DELAY+1 does not turn a pass into a fail.
- R4: Attempts may overlap. Triggers in consecutive cycles, including across slice boundaries, each give their own verdict DELAY cycles later.
- R5: A trigger in a cycle where `dis` is high never produces a verdict.
- R6: A one-cycle `dis` pulse in any cycle strictly inside an attempt's window cancels that attempt and every other attempt in flight. Triggers issued after the pulse are judged normally.
- R7: `dis` high in the cycle where a window closes suppresses both `fail` and `pass` in that cycle.
- R8: `dis` held high across many cycles cancels every attempt whose window touches it. An attempt triggered after `dis` falls is judged normally.
- R9: `fail` and `pass` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| trig | input | 1 | Starts a new attempt in this cycle |
| value | input | 1 | Condition sampled when an attempt's window closes |
| dis | input | 1 | Abort: clears all attempts and mutes the verdict |
| fail | output | 1 | One-cycle pulse: window closed with value low |
| pass | output | 1 | One-cycle pulse: window closed with value high |

## Verification
A stage bit that is lost, duplicated or moved shows at the ports as a verdict that is missing, repeated, or one cycle early or late. This appears DELAY cycles after the trigger, so every scenario drives at least one full window. A broken link between slices shifts only the attempts that cross it, which is why overlapping triggers are placed around bit 64. A stage bit that survives an abort shows as a verdict after a `dis` pulse. The bench compares every cycle of every scenario against a model that works out each attempt's window independently.

// File: rtl/dam_pkg.sv
package dam_pkg;

    // Number of slices needed for a chain of the given depth.
    function automatic int unsigned chunk_count(input int unsigned depth,
                                                input int unsigned slice_w);
        return (depth + slice_w - 1) / slice_w;
    endfunction

    // Width of slice idx: full slices first, the remainder in the last one.
    function automatic int unsigned chunk_width(input int unsigned depth,
                                                input int unsigned slice_w,
                                                input int unsigned idx);
        if ((idx + 1) * slice_w <= depth) return slice_w;
        return depth - idx * slice_w;
    endfunction

    typedef struct packed {
        logic fail;
        logic pass;
    } verdict_t;

endpackage

// File: rtl/dam_chunk.sv
module dam_chunk #(
    parameter int unsigned W = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic keep,
    input  logic inject,
    output logic carry_out
);

    typedef struct packed {
        logic [W-1:0] bits;
    } slice_t;

    slice_t slice_d;
    slice_t slice_q;

    // One masked shift per clock; the abort mask wipes the whole slice.
    always_comb begin
        slice_d      = slice_q;
        slice_d.bits = ((slice_q.bits << 1) | W'(inject)) & {W{keep}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slice_q <= '0;
        else        slice_q <= slice_d;
    end

    assign carry_out = slice_q.bits[W-1];

endmodule

// File: rtl/dam_judge.sv
module dam_judge (
    input  logic rst_n,
    input  logic due,
    input  logic value,
    input  logic dis,
    output logic fail,
    output logic pass
);

    dam_pkg::verdict_t verdict_d;

    always_comb begin
        verdict_d = '0;
        if (due && rst_n && !dis) begin
            verdict_d.fail = !value;
            verdict_d.pass = value;
        end
    end

    assign fail = verdict_d.fail;
    assign pass = verdict_d.pass;

endmodule

// File: rtl/delay_assert_mon.sv
module delay_assert_mon #(
    parameter int unsigned DELAY   = 130,
    parameter int unsigned CHUNK_W = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic value,
    input  logic dis,
    output logic fail,
    output logic pass
);

    localparam int unsigned NCHUNK = dam_pkg::chunk_count(DELAY, CHUNK_W);

    logic              keep;
    logic [NCHUNK:0]   link;

    assign keep    = ~dis;
    assign link[0] = trig;

    // Stage k-1 holds an attempt that is k cycles old; link[c+1] is the
    // oldest stage of slice c and feeds bit 0 of slice c+1.
    for (genvar c = 0; c < NCHUNK; c++) begin : g_slice
        localparam int unsigned SW = dam_pkg::chunk_width(DELAY, CHUNK_W, c);
        dam_chunk #(
            .W(SW)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .keep     (keep),
            .inject   (link[c]),
            .carry_out(link[c+1])
        );
    end

    dam_judge u_judge (
        .rst_n(rst_n),
        .due  (link[NCHUNK]),
        .value(value),
        .dis  (dis),
        .fail (fail),
        .pass (pass)
    );

endmodule

// File: rtl/delay_assert_mon_chk.sv
module delay_assert_mon_chk #(
    parameter int unsigned DELAY = 130
) (
    input logic clk,
    input logic rst_n,
    input logic trig,
    input logic value,
    input logic dis,
    input logic fail,
    input logic pass
);

    localparam int unsigned CW = $clog2(DELAY + 1) + 1;

    typedef struct packed {
        logic [CW-1:0] quiet;
        logic          armed;
        logic [CW-1:0] age;
    } track_t;

    track_t trk_d;
    track_t trk_q;

    // quiet: consecutive earlier cycles with dis low and out of reset.
    // age: cycles since the first accepted trigger after the last abort.
    always_comb begin
        trk_d = trk_q;
        if (!rst_n || dis) begin
            trk_d = '0;
        end else begin
            if (trk_q.quiet < CW'(DELAY)) trk_d.quiet = trk_q.quiet + 1'b1;
            if (trk_q.armed) begin
                if (trk_q.age < CW'(DELAY)) trk_d.age = trk_q.age + 1'b1;
            end else if (trig) begin
                trk_d.armed = 1'b1;
                trk_d.age   = CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    // R1 and R6: a verdict needs a full abort-free, reset-free window.
    p_quiet_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fail || pass) |-> (trk_q.quiet >= CW'(DELAY)));

    // R5: a verdict needs a trigger accepted (dis low) at least DELAY ago.
    p_needs_trigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fail || pass) |-> (trk_q.armed && trk_q.age >= CW'(DELAY)));

    // R7
    p_abort_mutes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dis |-> (!fail && !pass));

    // R9
    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fail && pass));

endmodule

bind delay_assert_mon delay_assert_mon_chk #(
    .DELAY(DELAY)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .trig (trig),
    .value(value),
    .dis  (dis),
    .fail (fail),
    .pass (pass)
);

// File: tb/delay_assert_mon_test.sv
module delay_assert_mon_test;

    localparam int DLY  = 130;
    localparam int MAXL = 2 * DLY + 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0;
    logic value = 1'b0;
    logic dis = 1'b0;
    logic fail;
    logic pass;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic tp [MAXL];
    logic vp [MAXL];
    logic dp [MAXL];
    logic rp [MAXL];

    always #2 clk = ~clk;

    delay_assert_mon #(
        .DELAY  (DLY),
        .CHUNK_W(64)
    ) uut (
        .clk  (clk),
        .rst_n(rst_n),
        .trig (trig),
        .value(value),
        .dis  (dis),
        .fail (fail),
        .pass (pass)
    );

    task automatic check(input string req, input int cyc, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s cycle %0d %s: actual=%b expected=%b", req, cyc, what, act, exp);
        end
    endtask

    task automatic clear_pat();
        for (int i = 0; i < MAXL; i++) begin
            tp[i] = 1'b0; vp[i] = 1'b1; dp[i] = 1'b0; rp[i] = 1'b0;
        end
    endtask

    task automatic reset_cycle();
        @(negedge clk);
        rst_n = 1'b0; trig = 1'b0; dis = 1'b0; value = 1'b0;
    endtask

    // Drives the pattern one cycle at a time and checks each cycle against
    // the window model: attempt j closes at j+DLY unless dis or reset hit it.
    task automatic run(input string req, input int len);
        reset_cycle();
        for (int k = 0; k < len; k++) begin
            logic due;
            int   j;
            @(negedge clk);
            rst_n = !rp[k]; trig = tp[k]; value = vp[k]; dis = dp[k];
            #1;
            j   = k - DLY;
            due = 1'b0;
            if (j >= 0 && tp[j]) begin
                due = 1'b1;
                for (int m = j; m <= k; m++) if (dp[m] || rp[m]) due = 1'b0;
            end
            check(req, k, "fail", fail, due && !vp[k]);
            check(req, k, "pass", pass, due && vp[k]);
            check("R9", k, "exclusive", fail && pass, 1'b0);
        end
        @(negedge clk);
        trig = 1'b0; dis = 1'b0; rst_n = 1'b1;
    endtask

    task automatic t_reset();
        reset_cycle();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R1", k, "fail in reset", fail, 1'b0);
            check("R1", k, "pass in reset", pass, 1'b0);
        end
        clear_pat();
        tp[0] = 1'b1; tp[3] = 1'b1; rp[3] = 1'b1; tp[20] = 1'b1;
        run("R1", 20 + DLY + 3);
    endtask

    task automatic t_single();
        clear_pat(); tp[0] = 1'b1; vp[DLY] = 1'b0;
        run("R2", DLY + 4);
        clear_pat(); tp[0] = 1'b1;
        run("R2", DLY + 4);
    endtask

    task automatic t_ignore_value();
        clear_pat();
        for (int i = 0; i < MAXL; i++) vp[i] = 1'b0;
        tp[0] = 1'b1; vp[DLY] = 1'b1;
        run("R3", DLY + 4);
    endtask

    task automatic t_overlap();
        clear_pat();
        tp[0] = 1'b1; tp[1] = 1'b1; tp[2] = 1'b1;
        tp[62] = 1'b1; tp[63] = 1'b1; tp[64] = 1'b1; tp[65] = 1'b1;
        vp[DLY+1] = 1'b0; vp[DLY+63] = 1'b0; vp[DLY+65] = 1'b0;
        run("R4", DLY + 70);
    endtask

    task automatic t_trigger_masked();
        clear_pat();
        tp[0] = 1'b1; dp[0] = 1'b1; vp[DLY] = 1'b0;
        tp[1] = 1'b1; vp[DLY+1] = 1'b0;
        run("R5", DLY + 5);
    endtask

    task automatic t_pulse();
        clear_pat();
        tp[0] = 1'b1; tp[10] = 1'b1; tp[70] = 1'b1;
        dp[64] = 1'b1; tp[65] = 1'b1;
        vp[DLY] = 1'b0; vp[DLY+10] = 1'b0; vp[DLY+65] = 1'b0;
        run("R6", DLY + 75);
    endtask

    task automatic t_end_abort();
        clear_pat();
        tp[0] = 1'b1; vp[DLY] = 1'b0; dp[DLY] = 1'b1;
        tp[1] = 1'b1; vp[DLY+1] = 1'b0;
        run("R7", DLY + 5);
    endtask

    task automatic t_held();
        clear_pat();
        for (int i = 5; i <= 100; i++) dp[i] = 1'b1;
        tp[3] = 1'b1; tp[50] = 1'b1; tp[101] = 1'b1; vp[101+DLY] = 1'b0;
        run("R8", 101 + DLY + 4);
    endtask

    initial begin
        t_reset();
        t_single();
        t_ignore_value();
        t_overlap();
        t_trigger_masked();
        t_pulse();
        t_end_abort();
        t_held();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule